// File: doc/BRIEF.md
# Destination Routing Table

This block turns the 4-bit destination address of an arriving packet into the 2-bit number of the output port that should carry it. It holds sixteen 2-bit entries, one for each address. The table is filled after reset through a 32-bit serial scan chain, which takes one bit per clock cycle while the scan enable is high. The first bit shifted in is the upper bit of entry 15, and the last is the lower bit of entry 0.

A small state machine tracks the fill. It has three states. EMPTY is the state after reset, before any bit has arrived. FILLING means some bits have arrived but fewer than 32. READY means the table is complete. The transitions are:

- EMPTY to FILLING on the first shift.
- EMPTY or FILLING to READY on the shift that completes the 32nd bit.
- READY stays in READY until the next reset.

While the table is not ready, every lookup is reported invalid. Once the table is ready, scan activity no longer changes it.

A lookup takes one cycle. A requester presents an address with a strobe. The address is captured at the next clock edge. The port number is then read from the table combinationally from the captured address, together with a valid flag. The captured address, and therefore the port output, holds while the strobe is low.

Top module: `dest_route_table`

## Requirements
- R1: While reset is asserted, and right after it, `table_ready` and `port_valid` are 0.
- R2: The chain advances by one bit on each clock edge where `scan_en` is 1. On edges where `scan_en` is 0 the table contents are unchanged, whatever `scan_in` does.
- R3: Bit k of the scan stream (k = 0 first) is stored in entry 15 - k/2 (integer division). Even k gives the entry's bit 1 and odd k gives its bit 0.
- R4: `table_ready` is 0 after 31 shifts. It becomes 1 on the clock edge that takes the 32nd shift, and it stays 1 until reset.
- R5: While `table_ready` is 0, `port_valid` is 0, even when lookups are requested.
- R6: If `addr_valid` is 1 with address A at an edge and the table is ready, then after that edge `port_valid` is 1 and `port_out` equals entry A.
- R7: If `addr_valid` is 0 at an edge, then after that edge `port_valid` is 0 and `port_out` keeps its previous value.
- R8: In READY, `scan_en` and `scan_in` have no effect on any entry.
- R9: A reset clears `table_ready`. A new 32-bit load then installs new contents, which lookups return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Shift one scan bit this cycle |
| scan_in | input | 1 | Serial table data |
| addr_valid | input | 1 | Lookup request strobe |
| addr_in | input | 4 | Packet destination address |
| port_out | output | 2 | Output port number for the captured address |
| port_valid | output | 1 | `port_out` is a valid lookup result |
| table_ready | output | 1 | Table fully loaded |

## Verification
Several rules are checked by the assertions on every cycle:

- The chain holds its contents when no shift is allowed, and once the table is frozen.
- Each shift places the serial bit at the chain's tail.
- The ready flag rises only on the final counted shift and never falls outside reset.
- The valid flag follows the registered strobe and stays gated by the ready flag.
- The captured address holds without a strobe.

Some behaviour only the bench scenarios can show:

- The mapping of stream positions to entries and bit positions.
- The exact cycle at which the table becomes ready.
- That a load with idle gaps still lands every bit correctly.
- That a full reload after a reset replaces every entry.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int DEF_ADDR_W = 4;
    localparam int DEF_PORT_W = 2;

    typedef enum logic [1:0] {
        LD_EMPTY   = 2'd0,
        LD_FILLING = 2'd1,
        LD_READY   = 2'd2
    } load_state_t;

endpackage

// File: rtl/rt_scan_chain.sv
module rt_scan_chain #(
    parameter int CHAIN_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_i,
    input  logic                 serial_i,
    input  logic                 frozen_i,
    output logic [CHAIN_LEN-1:0] chain_o
);

    logic [CHAIN_LEN-1:0] chain_q;

    // New bits enter at bit 0; older bits move toward the MSB.
    generate
        if (CHAIN_LEN > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else if (shift_i) begin
                    chain_q <= {chain_q[CHAIN_LEN-2:0], serial_i};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else if (shift_i) begin
                    chain_q <= serial_i;
                end
            end
        end
    endgenerate

    assign chain_o = chain_q;

    // R2: no shift, no change
    a_r2_hold_without_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(chain_q));

    // R3: each shift lands the serial bit at the tail
    a_r3_tail_bit: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> chain_q[0] == $past(serial_i));

    // R8: a frozen table never changes
    a_r8_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        frozen_i |=> $stable(chain_q));

endmodule

// File: rtl/rt_load_ctrl.sv
module rt_load_ctrl
    import rt_pkg::*;
#(
    parameter int CHAIN_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_en_i,
    output logic shift_o,
    output logic ready_o
);

    localparam int CNT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAIN_LEN - 1);

    load_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             shift_ok;
    logic             at_last;

    assign at_last = (cnt_q == LAST_BIT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_EMPTY, LD_FILLING: begin
                if (scan_en_i && at_last) begin
                    state_d = LD_READY;
                end else if (scan_en_i) begin
                    state_d = LD_FILLING;
                end
            end
            LD_READY: state_d = LD_READY;
            default:  state_d = LD_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        shift_ok = 1'b0;
        ready_o  = 1'b0;
        unique case (state_q)
            LD_EMPTY, LD_FILLING: shift_ok = scan_en_i;
            LD_READY:             ready_o  = 1'b1;
            default: begin
                shift_ok = 1'b0;
                ready_o  = 1'b0;
            end
        endcase
    end

    assign shift_o = shift_ok;

    // Shift counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (shift_ok && !at_last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: ready rises only on the final counted shift
    a_r4_ready_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(cnt_q) == LAST_BIT) && $past(scan_en_i));

    // R4: ready never drops outside reset
    a_r4_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

endmodule

// File: rtl/rt_lookup.sv
module rt_lookup #(
    parameter int ADDR_W = 4,
    parameter int PORT_W = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          valid_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          ready_i,
    input  logic [(1<<ADDR_W)*PORT_W-1:0] chain_i,
    output logic [PORT_W-1:0]             port_o,
    output logic                          valid_o
);

    localparam int ENTRIES = 1 << ADDR_W;

    logic [ADDR_W-1:0] addr_q;
    logic              vld_q;
    logic [PORT_W-1:0] entry [ENTRIES];

    // Entry g occupies chain bits [g*PORT_W +: PORT_W].
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
            assign entry[g] = chain_i[g*PORT_W +: PORT_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= valid_i;
            if (valid_i) begin
                addr_q <= addr_i;
            end
        end
    end

    assign port_o  = entry[addr_q];
    assign valid_o = vld_q && ready_i;

    // R6: a request against a ready table yields a valid result
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(valid_i) && ready_i) |-> valid_o);

    // R7: no request, no valid result
    a_r7_idle_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_i) |-> !valid_o);

    // R7: the captured address holds without a request
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(addr_q));

endmodule

// File: rtl/dest_route_table.sv
module dest_route_table
    import rt_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int PORT_W = DEF_PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_en,
    input  logic              scan_in,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [PORT_W-1:0] port_out,
    output logic              port_valid,
    output logic              table_ready
);

    localparam int CHAIN_LEN = (1 << ADDR_W) * PORT_W;

    logic                 shift_en;
    logic                 ready;
    logic [CHAIN_LEN-1:0] chain;

    rt_load_ctrl #(
        .CHAIN_LEN(CHAIN_LEN)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_en_i(scan_en),
        .shift_o  (shift_en),
        .ready_o  (ready)
    );

    rt_scan_chain #(
        .CHAIN_LEN(CHAIN_LEN)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_en),
        .serial_i(scan_in),
        .frozen_i(ready),
        .chain_o (chain)
    );

    rt_lookup #(
        .ADDR_W(ADDR_W),
        .PORT_W(PORT_W)
    ) u_lookup (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(addr_valid),
        .addr_i (addr_in),
        .ready_i(ready),
        .chain_i(chain),
        .port_o (port_out),
        .valid_o(port_valid)
    );

    assign table_ready = ready;

    // R5: no valid result from an incomplete table
    a_r5_valid_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid |-> table_ready);

    // R1: the cycle after a reset shows an empty table
    a_r1_after_reset: assert property (@(posedge clk)
        !rst_n |=> !table_ready && !port_valid);

endmodule

// File: tb/dest_route_table_tb.sv
module dest_route_table_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_en = 1'b0;
    logic       scan_in = 1'b0;
    logic       addr_valid = 1'b0;
    logic [3:0] addr_in = 4'd0;
    logic [1:0] port_out;
    logic       port_valid;
    logic       table_ready;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dest_route_table u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_en    (scan_en),
        .scan_in    (scan_in),
        .addr_valid (addr_valid),
        .addr_in    (addr_in),
        .port_out   (port_out),
        .port_valid (port_valid),
        .table_ready(table_ready)
    );

    // Lookup vectors: address order is deliberately scrambled.
    localparam logic [3:0] VEC [16] = '{
        4'd7, 4'd0, 4'd15, 4'd3, 4'd9, 4'd12, 4'd1, 4'd14,
        4'd5, 4'd10, 4'd2, 4'd13, 4'd8, 4'd4, 4'd11, 4'd6
    };

    function automatic logic [1:0] pat(input int sel, input int i);
        if (sel == 0) return 2'((i ^ (i >> 2)) & 3);
        else if (sel == 1) return 2'((i * 3 + 2) & 3);
        else return 2'(~i & 3);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk);
        scan_en = 1'b1;
        scan_in = b;
        @(posedge clk);
        #1;
        @(negedge clk);
        scan_en = 1'b0;
    endtask

    // Stream position k carries entry 15-k/2, bit 1 when k is even (R3).
    function automatic logic stream_bit(input int sel, input int k);
        logic [1:0] e;
        e = pat(sel, 15 - k / 2);
        return (k % 2 == 0) ? e[1] : e[0];
    endfunction

    task automatic load(input int sel, input int first, input int last, input bit gaps);
        for (int k = first; k <= last; k++) begin
            shift_bit(stream_bit(sel, k));
            if (gaps && (k % 5 == 2)) begin
                @(negedge clk);
                scan_in = ~scan_in;
                @(negedge clk);
                scan_in = ~scan_in;
            end
        end
    endtask

    task automatic lookup(input logic [3:0] a, input int exp, input string req);
        @(negedge clk);
        addr_valid = 1'b1;
        addr_in    = a;
        @(posedge clk);
        #1;
        check({req, " port_valid"}, int'(port_valid), 1);
        check({req, " port_out"}, int'(port_out), exp);
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    task automatic walk(input int sel, input string req);
        for (int v = 0; v < 16; v++) begin
            lookup(VEC[v], int'(pat(sel, int'(VEC[v]))), req);
        end
    endtask

    initial begin : watchdog
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 ready in reset", int'(table_ready), 0);
        check("R1 valid in reset", int'(port_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 ready after reset", int'(table_ready), 0);

        // R2 and R3: load pattern 0 with idle gaps, 31 bits first
        load(0, 0, 30, 1'b1);
        check("R4 ready after 31 shifts", int'(table_ready), 0);

        // R5: request lookups before the table is ready
        @(negedge clk);
        addr_valid = 1'b1;
        addr_in    = 4'd5;
        @(posedge clk);
        #1;
        check("R5 valid gated", int'(port_valid), 0);
        @(negedge clk);
        addr_valid = 1'b0;

        // R4: the 32nd shift sets ready on its own edge
        @(negedge clk);
        scan_en = 1'b1;
        scan_in = stream_bit(0, 31);
        @(posedge clk);
        #1;
        check("R4 ready on 32nd shift", int'(table_ready), 1);
        @(negedge clk);
        scan_en = 1'b0;

        // R6 and R3: walk the vector table
        walk(0, "R6/R3 lookup");

        // R7: no request, result invalid and held
        lookup(4'd9, int'(pat(0, 9)), "R7 setup");
        @(posedge clk);
        #1;
        check("R7 valid low", int'(port_valid), 0);
        check("R7 port held", int'(port_out), int'(pat(0, 9)));

        // R8: scanning once ready changes nothing
        load(1, 0, 31, 1'b0);
        check("R8 ready kept", int'(table_ready), 1);
        walk(0, "R8 frozen");

        // R9: reset then reload a new pattern
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R9 ready cleared", int'(table_ready), 0);
        @(negedge clk);
        rst_n = 1'b1;
        load(2, 0, 31, 1'b0);
        check("R9 ready after reload", int'(table_ready), 1);
        walk(2, "R9 reload");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule